// File: doc/BRIEF.md
# NAND Command Gate with Power-Up Busy and Write-Protect Timing

This block sits between the host-side command pins of a NAND-style device model and its command register. It tracks the supply state, holds the ready/busy flag low during the power-on initialization window and during the busy time after a reset command, and decides which latched command bytes reach the downstream array controller. While the device is busy, only the status-read command passes. Program setup and erase setup pass only if the write-protect input has been high long enough before the write-enable rise that latches them.

A command is captured when the command-latch input is high and the active-low write-enable input is sampled rising. An accepted command leaves the block as a one-cycle strobe carrying the command byte. A status-read command switches the I/O output to a live status byte. Busy lengths and the write-protect setup window are clock-cycle parameters: `INIT_CYC`, `RST_CYC` and `TWW_CYC`.

Top module: `nand_cmd_gate`

## Requirements
- R1: While `pwr_good` is low, `ready` is low in the same cycle, `cmd_stb` stays low and no command is accepted. After `rst_n` is released with power absent, `ready`, `cmd_stb`, `io_out` and `rd_setup` are all 0.
- R2: After `pwr_good` rises, `ready` stays low for exactly `INIT_CYC` clock cycles and then goes high.
- R3: While `ready` is low, a command byte of 0x70 is accepted and every other byte is ignored, producing no strobe.
- R4: When power-up initialization ends, `rd_setup` goes to 1 with no command issued. It is cleared by any accepted command other than 0x00 or 0x70, and it is set again by 0x00.
- R5: An accepted 0xFF while ready drives `ready` low for exactly `RST_CYC` cycles, counted from the cycle of its strobe. Afterwards the next command is accepted normally.
- R6: The status byte is {`wp_n`, `ready`, 6'b0}, so bit 7 follows the write-protect pin and bit 6 is 1 only when ready. After an accepted 0x70, `io_out` shows the current status byte, including while busy, until another command is accepted. Otherwise `io_out` is 0x00.
- R7: When ready, 0x80 and 0x60 are accepted only if `wp_n` is high. With `wp_n` low they are rejected.
- R8: 0x80 or 0x60 is accepted only if `wp_n` was sampled high on the clock edge where the write-enable rise is detected and on each of the `TWW_CYC` edges before it. A change inside that window rejects the command.
- R9: `cmd_stb` is a single-cycle pulse on the cycle after the write-enable rise is detected, with `cmd_byte` holding the command byte. Rejected or ignored commands give no pulse.
- R10: A drop of `pwr_good` discards a command whose write-enable rise has not yet been seen. It also aborts any busy period, and when power returns a full `INIT_CYC` initialization is run.
- R11: When ready, any other command byte, such as 0x00 or 0x30, is accepted whatever the level of `wp_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply valid level |
| cmd_latch | input | 1 | Command latch enable |
| we_n | input | 1 | Active-low write enable; the rise latches the command |
| io_in | input | 8 | Command byte input |
| wp_n | input | 1 | Write-protect pin; low protects the device |
| ready | output | 1 | 1 = ready, 0 = busy |
| rd_setup | output | 1 | Command state is read-setup |
| io_out | output | 8 | Status byte while in status-read mode, else 0 |
| cmd_stb | output | 1 | One-cycle accepted-command strobe |
| cmd_byte | output | 8 | Byte of the last accepted command |

## Verification
The bench goes after the write-protect setup boundary. With `TWW_CYC` at 4, it issues a program setup one cycle too early, which must be rejected, and an erase setup at the exact limit, which must be accepted. A design with an off-by-one counter would flip one of these outcomes. It also issues a non-status command inside both the power-up window and the reset window; a design that forgets to gate busy time would strobe it. The bench drops power between a write-enable fall and its rise, and again in the middle of a reset busy period. A design that keeps pending state would either strobe the stale byte or shorten the following initialization. Status bits are read while busy and after ready, which catches a status register that freezes bit 6 or ignores the write-protect pin.

// File: rtl/nand_gate_pkg.sv
package nand_gate_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_RDY  = 2'd2,
    ST_RST  = 2'd3
  } seq_state_t;

  localparam logic [7:0] OP_READ0  = 8'h00;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_PROG   = 8'h80;
  localparam logic [7:0] OP_ERASE  = 8'h60;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  // Program and erase setup need write permission
  function automatic logic is_setup_op(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

  // Status byte layout: protect level on bit 7, ready on bit 6
  function automatic logic [7:0] status_byte(input logic wp_lvl, input logic rdy);
    return {wp_lvl, rdy, 6'b0};
  endfunction

  // Next read-setup state after an accepted command
  function automatic logic next_rd_setup(input logic [7:0] op, input logic cur);
    if (op == OP_READ0)  return 1'b1;
    if (op == OP_STATUS) return cur;
    return 1'b0;
  endfunction

endpackage

// File: rtl/nand_busy_seq.sv
module nand_busy_seq
  import nand_gate_pkg::*;
#(
  parameter int unsigned INIT_CYC = 1250000,
  parameter int unsigned RST_CYC  = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic reset_req,
  output logic ready,
  output logic init_done
);
  localparam int unsigned MAXC = (INIT_CYC > RST_CYC) ? INIT_CYC : RST_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  assign ready     = (state == ST_RDY) && pwr_good;
  assign init_done = (state == ST_INIT) && (cnt == INIT_LAST) && pwr_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else if (!pwr_good) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          state <= ST_INIT;
          cnt   <= '0;
        end
        ST_INIT: begin
          if (cnt == INIT_LAST) begin
            state <= ST_RDY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RDY: begin
          if (reset_req) begin
            state <= ST_RST;
            cnt   <= '0;
          end
        end
        default: begin
          if (cnt == RST_LAST) begin
            state <= ST_RDY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_wp_guard.sv
module nand_wp_guard #(
  parameter int unsigned TWW_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic wp_chg,
  output logic wp_ok
);
  localparam int unsigned CW = $clog2(TWW_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(TWW_CYC);

  logic          wp_q;
  logic [CW-1:0] held;

  assign wp_chg = (wp_n != wp_q);
  assign wp_ok  = wp_n && !wp_chg && (held >= SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= 1'b0;
      held <= '0;
    end else begin
      wp_q <= wp_n;
      if (wp_chg)          held <= CW'(1);
      else if (held < SAT) held <= held + 1'b1;
    end
  end
endmodule

// File: rtl/nand_cmd_gate.sv
module nand_cmd_gate
  import nand_gate_pkg::*;
#(
  parameter int unsigned INIT_CYC = 1250000,
  parameter int unsigned RST_CYC  = 1250,
  parameter int unsigned TWW_CYC  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       cmd_latch,
  input  logic       we_n,
  input  logic [7:0] io_in,
  input  logic       wp_n,
  output logic       ready,
  output logic       rd_setup,
  output logic [7:0] io_out,
  output logic       cmd_stb,
  output logic [7:0] cmd_byte
);
  logic       we_q;
  logic       we_rise;
  logic       permit;
  logic       acc_evt;
  logic       reset_req;
  logic       init_done;
  logic       wp_ok;
  logic       wp_chg;
  logic       stat_mode;
  logic [7:0] status;

  nand_busy_seq #(.INIT_CYC(INIT_CYC), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .reset_req(reset_req),
    .ready(ready), .init_done(init_done)
  );

  nand_wp_guard #(.TWW_CYC(TWW_CYC)) u_wp (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wp_chg(wp_chg), .wp_ok(wp_ok)
  );

  // Named events for the checker
  assign we_rise   = cmd_latch && we_n && !we_q;
  assign permit    = ready ? (is_setup_op(io_in) ? wp_ok : 1'b1)
                           : (io_in == OP_STATUS);
  assign acc_evt   = we_rise && pwr_good && permit;
  assign reset_req = acc_evt && ready && (io_in == OP_RESET);

  assign status = status_byte(wp_n, ready);
  assign io_out = stat_mode ? status : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      cmd_stb   <= 1'b0;
      cmd_byte  <= 8'h00;
      stat_mode <= 1'b0;
      rd_setup  <= 1'b0;
    end else begin
      we_q    <= we_n;
      cmd_stb <= acc_evt;
      if (acc_evt) cmd_byte <= io_in;
      if (!pwr_good) begin
        stat_mode <= 1'b0;
        rd_setup  <= 1'b0;
      end else begin
        if (acc_evt) stat_mode <= (io_in == OP_STATUS);
        if (init_done)    rd_setup <= 1'b1;
        else if (acc_evt) rd_setup <= next_rd_setup(io_in, rd_setup);
      end
    end
  end
endmodule

// File: rtl/nand_gate_chk.sv
module nand_gate_chk #(
  parameter int unsigned TWW_CYC = 25
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       wp_n,
  input logic [7:0] io_in,
  input logic       ready,
  input logic       rd_setup,
  input logic [7:0] io_out,
  input logic       cmd_stb,
  input logic [7:0] cmd_byte,
  input logic       acc_evt,
  input logic       init_done
);
  localparam int unsigned HW = $clog2(TWW_CYC + 2);
  localparam logic [HW-1:0] HSAT = HW'(TWW_CYC);

  // Consecutive high samples of wp_n before the current edge
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_run <= '0;
    else if (!wp_n)       hi_run <= '0;
    else if (hi_run < HSAT) hi_run <= hi_run + 1'b1;
  end

  // R1
  no_stb_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !cmd_stb);
  // R2
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (ready || !pwr_good));
  // R3
  busy_only_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !ready) |-> (io_in == 8'h70));
  // R4
  read_setup_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (rd_setup || !pwr_good));
  // R5
  reset_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_byte == 8'hFF) |-> !ready);
  // R6
  status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out != 8'h00) |-> (io_out[7] == wp_n && io_out[6] == ready && io_out[5:0] == 6'd0));
  // R7
  setup_needs_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && (io_in == 8'h80 || io_in == 8'h60)) |-> wp_n);
  // R8
  setup_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && (io_in == 8'h80 || io_in == 8'h60)) |-> (hi_run >= HSAT));
  // R9
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  // R9
  stb_carries_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> (cmd_stb && cmd_byte == $past(io_in)));
endmodule

bind nand_cmd_gate nand_gate_chk #(.TWW_CYC(TWW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wp_n(wp_n), .io_in(io_in),
  .ready(ready), .rd_setup(rd_setup), .io_out(io_out), .cmd_stb(cmd_stb),
  .cmd_byte(cmd_byte), .acc_evt(acc_evt), .init_done(init_done)
);

// File: tb/sim_nand_cmd_gate.sv
`timescale 1ns/1ps
module sim_nand_cmd_gate;
  localparam int unsigned INIT_C = 20;
  localparam int unsigned RST_C  = 8;
  localparam int unsigned TWW_C  = 4;

  logic       clk = 1'b0;
  logic       rst_n, pwr_good, cmd_latch, we_n, wp_n;
  logic [7:0] io_in;
  logic       ready, rd_setup, cmd_stb;
  logic [7:0] io_out, cmd_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  nand_cmd_gate #(.INIT_CYC(INIT_C), .RST_CYC(RST_C), .TWW_CYC(TWW_C)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cmd_latch(cmd_latch),
    .we_n(we_n), .io_in(io_in), .wp_n(wp_n), .ready(ready), .rd_setup(rd_setup),
    .io_out(io_out), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: starts and ends on a falling clock edge
  task automatic issue(input logic [7:0] op, input bit acc, input string tag);
    if (acc) exp_q.push_back(op);
    cmd_latch = 1'b1; io_in = op; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cmd_latch = 1'b0;
    chk(cmd_stb == acc, tag, int'(cmd_stb), int'(acc));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!ready && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Monitor: scoreboard on the strobe, R9
  always @(negedge clk) begin
    if (rst_n && cmd_stb) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected strobe", int'(cmd_byte), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(cmd_byte == e, "R9 strobe byte", int'(cmd_byte), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; pwr_good = 1'b0; cmd_latch = 1'b0; we_n = 1'b1;
    wp_n = 1'b1; io_in = 8'h00;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    chk(cmd_stb == 1'b0, "R1 reset strobe", int'(cmd_stb), 0);
    chk(io_out == 8'h00, "R1 reset io_out", int'(io_out), 0);
    chk(rd_setup == 1'b0, "R1 reset rd_setup", int'(rd_setup), 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(8'h70, 1'b0, "R1 unpowered status ignored");

    // Power-up
    pwr_good = 1'b1;
    @(negedge clk);
    count_busy(n);
    chk(n == INIT_C, "R2 init length", n, INIT_C);
    chk(rd_setup == 1'b1, "R4 read-setup default", int'(rd_setup), 1);
    issue(8'h30, 1'b1, "R11 plain command");
    chk(rd_setup == 1'b0, "R4 cleared by 30h", int'(rd_setup), 0);
    issue(8'h00, 1'b1, "R11 read command");
    chk(rd_setup == 1'b1, "R4 set by 00h", int'(rd_setup), 1);
    @(negedge clk);
    chk(cmd_stb == 1'b0, "R9 single pulse", int'(cmd_stb), 0);

    // Write protect levels
    issue(8'h80, 1'b1, "R7 program allowed");
    issue(8'h60, 1'b1, "R7 erase allowed");
    wp_n = 1'b0;
    repeat (8) @(negedge clk);
    issue(8'h80, 1'b0, "R7 program blocked");
    issue(8'h60, 1'b0, "R7 erase blocked");
    issue(8'h30, 1'b1, "R11 accepted while protected");
    issue(8'h70, 1'b1, "R6 status read");
    chk(io_out == 8'h40, "R6 status protected", int'(io_out), 8'h40);
    wp_n = 1'b1;
    #1;
    chk(io_out == 8'hC0, "R6 status follows wp", int'(io_out), 8'hC0);
    @(negedge clk);
    issue(8'h00, 1'b1, "R6 leave status");
    chk(io_out == 8'h00, "R6 status mode left", int'(io_out), 0);

    // Setup window
    wp_n = 1'b0;
    repeat (8) @(negedge clk);
    wp_n = 1'b1;
    repeat (2) @(negedge clk);
    issue(8'h80, 1'b0, "R8 one cycle short");
    wp_n = 1'b0;
    repeat (8) @(negedge clk);
    wp_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(8'h60, 1'b1, "R8 exact window");
    repeat (8) @(negedge clk);
    wp_n = 1'b0;
    @(negedge clk);
    wp_n = 1'b1;
    @(negedge clk);
    issue(8'h80, 1'b0, "R8 glitch in window");
    repeat (8) @(negedge clk);

    // Reset busy
    issue(8'hFF, 1'b1, "R5 reset accepted");
    chk(ready == 1'b0, "R5 busy after reset", int'(ready), 0);
    issue(8'h90, 1'b0, "R3 busy ignores 90h");
    issue(8'h70, 1'b1, "R3 busy takes status");
    chk(io_out == 8'h80, "R6 busy status", int'(io_out), 8'h80);
    count_busy(n);
    chk(n == RST_C - 4, "R5 reset length", n, RST_C - 4);
    chk(io_out == 8'hC0, "R6 ready status", int'(io_out), 8'hC0);
    issue(8'h80, 1'b1, "R5 next command after reset");

    // Pending command discarded by power loss
    cmd_latch = 1'b1; io_in = 8'h00; we_n = 1'b0;
    @(negedge clk);
    pwr_good = 1'b0; we_n = 1'b1;
    #1;
    chk(ready == 1'b0, "R10 immediate busy", int'(ready), 0);
    @(negedge clk);
    chk(cmd_stb == 1'b0, "R10 pending discarded", int'(cmd_stb), 0);
    @(negedge clk);
    cmd_latch = 1'b0;
    chk(cmd_stb == 1'b0, "R10 pending discarded late", int'(cmd_stb), 0);
    pwr_good = 1'b1;
    @(negedge clk);
    count_busy(n);
    chk(n == INIT_C, "R10 full init after loss", n, INIT_C);

    // Loss during reset busy, then commands during init
    issue(8'hFF, 1'b1, "R5 second reset");
    repeat (2) @(negedge clk);
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    pwr_good = 1'b1;
    issue(8'h00, 1'b0, "R3 init ignores 00h");
    issue(8'h70, 1'b1, "R3 init takes status");
    chk(io_out == 8'h80, "R6 init status", int'(io_out), 8'h80);
    count_busy(n);
    chk(n == INIT_C - 3, "R10 restart init length", n, INIT_C - 3);
    chk(io_out == 8'hC0, "R6 status after init", int'(io_out), 8'hC0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 missing strobe", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule